// File: doc/BRIEF.md
# Configuration-Aware Boundary-Scan Test Access Port

This block is the boundary-scan test access port of a programmable device. It follows the sixteen-state controller of IEEE 1149.1 on the rising edge of `tck` and holds a 3-bit instruction. It owns two data registers: a one-bit bypass stage and a 32-bit identification register. Every other data register lives outside the block. These are the boundary chain, two user chains, a readback chain and a configuration chain. For them the block drives select lines and capture, shift and update strobes, and it reads their serial output back on one shared input, `ext_tdo`.

A side-band input, `configuring`, is high while the device is still loading its configuration. Some instructions may not be used in that phase. When one of them is loaded, the block treats it exactly like BYPASS. The same flag also appears in the most significant bit of the value captured into the instruction register. Test software can therefore read the configuration state during any instruction scan.

Top module: `jtag_cfg_tap`

## Requirements
- R1: The controller moves through the sixteen standard states on each rising `tck` edge as `tms` directs. Five consecutive cycles with `tms` high reach Test-Logic-Reset from any state.
- R2: The instruction becomes IDCODE (110) when `trst_n` is low at a rising `tck` edge, and on every edge spent in Test-Logic-Reset. A data scan that follows returns the identification value.
- R3: Capture-IR loads 3'b001 while `configuring` is high and 3'b101 while it is low. Bit 0 shifts out on `tdo` first.
- R4: The identification value, from bit 31 down to bit 0, is: the 4-bit version parameter, family 0000010, array size 000001010, manufacturer 00001001001, and a 1 in bit 0. It shifts out LSB first.
- R5: Instruction codes are EXTEST 000, SAMPLE 001, USER1 010, USER2 011, READBACK 100, CONFIGURE 101, IDCODE 110 and BYPASS 111. The held instruction, and so every select line, changes only in Update-IR or Test-Logic-Reset.
- R6: While `configuring` is high, EXTEST, USER1, USER2, READBACK and CONFIGURE behave as BYPASS. The scan path is one bit long, and neither `extest_mode` nor any external select line is raised.
- R7: While `configuring` is low, every instruction is honoured. SAMPLE, in either state, raises `sel_boundary`. EXTEST raises both `sel_boundary` and `extest_mode`. USER1, USER2, READBACK and CONFIGURE each raise their own select line. While an external chain is selected, Shift-DR passes `ext_tdo` to `tdo`. At most one select line is high at a time.
- R8: BYPASS selects the one-bit register. It captures 0, so serial data appears on `tdo` one shift later.
- R9: `tdo` and `tdo_oe` are updated on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR. In every other state `tdo` is 0.
- R10: `dr_capture`, `dr_shift` and `dr_update` are high exactly while the controller is in Capture-DR, Shift-DR and Update-DR. `dr_update` is reached only from Exit1-DR or Exit2-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising `tck` |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data into the selected register |
| configuring | input | 1 | High while the device is still being configured |
| ext_tdo | input | 1 | Serial output of whichever external chain is selected |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` carries shift data |
| sel_boundary | output | 1 | Boundary chain selected (SAMPLE or EXTEST) |
| sel_user1 | output | 1 | First user chain selected |
| sel_user2 | output | 1 | Second user chain selected |
| sel_readback | output | 1 | Readback chain selected |
| sel_configure | output | 1 | Configuration chain selected |
| extest_mode | output | 1 | Boundary cells drive the pins |
| dr_capture | output | 1 | Controller in Capture-DR |
| dr_shift | output | 1 | Controller in Shift-DR |
| dr_update | output | 1 | Controller in Update-DR |

## Verification
The assertions assume that `configuring` is stable across the cycle that samples it. They also assume that `trst_n` is held low for at least one rising edge before any check matters. The stimulus changes `configuring` only while the controller rests in Run-Test/Idle. It drives `tms`, `tdi` and `trst_n` one nanosecond after a rising edge, and starts with three reset cycles. The external chains are modelled by the bench as plain shift registers, clocked by the block's own select and shift strobes. The gating checks therefore show at the serial output whenever a blocked instruction would have opened an external path.

// File: rtl/jtag_tap_pkg.sv
// Shared types for the configuration-aware test access port.
// Assumes a 3-bit instruction register and a 32-bit identification register.
package jtag_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [6:0]  ID_FAMILY = 7'b0000010;
    localparam logic [8:0]  ID_ARRAY  = 9'b000001010;
    localparam logic [10:0] ID_MFR    = 11'b00001001001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SCAN, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SCAN, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST    = 3'b000,
        OP_SAMPLE    = 3'b001,
        OP_USER1     = 3'b010,
        OP_USER2     = 3'b011,
        OP_READBACK  = 3'b100,
        OP_CONFIGURE = 3'b101,
        OP_IDCODE    = 3'b110,
        OP_BYPASS    = 3'b111
    } opcode_e;

    typedef struct packed {
        logic byp;
        logic idc;
        logic bnd;
        logic usr1;
        logic usr2;
        logic rdbk;
        logic cfgp;
        logic ext;
    } dr_sel_t;

endpackage

// File: rtl/jtag_tap_fsm.sv
// Sixteen-state controller sequencer, advanced by tms on rising tck.
// Assumes trst_n is sampled synchronously; low forces the reset state.
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next state from current state and tms.
    always_comb begin
        case (state)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_DR_SCAN  : ST_IDLE;
            ST_DR_SCAN:  nxt = tms ? ST_IR_SCAN  : ST_DR_CAP;
            ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   nxt = tms ? ST_DR_SCAN  : ST_IDLE;
            ST_IR_SCAN:  nxt = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   nxt = tms ? ST_DR_SCAN  : ST_IDLE;
            default:     nxt = ST_RESET;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

endmodule

// File: rtl/jtag_tap_ir.sv
// Instruction shift stage and held instruction.
// Capture puts the inverted configuring flag in the MSB and 01 below it.
// The held instruction changes only in Update-IR or the reset state.
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            configuring,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_sr,
    output opcode_e         ir_hold
);

    localparam logic [IR_W-1:0] CAP_LOW = IR_W'(1);

    logic [IR_W-1:0] cap_val;
    assign cap_val = {~configuring, CAP_LOW[IR_W-2:0]};

    // Capture and shift of the instruction stage.
    always_ff @(posedge tck) begin
        if (!trst_n)                    ir_sr <= '0;
        else if (state == ST_IR_CAP)    ir_sr <= cap_val;
        else if (state == ST_IR_SHIFT)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Held instruction: identification on reset, new code on update.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_RESET) ir_hold <= OP_IDCODE;
        else if (state == ST_IR_UPD)      ir_hold <= opcode_e'(ir_sr);
    end

endmodule

// File: rtl/jtag_tap_decode.sv
// Turns the held instruction into one data-register select.
// Codes not allowed in the present configuration phase fall back to bypass.
module jtag_tap_decode
    import jtag_tap_pkg::*;
(
    input  opcode_e ir_hold,
    input  logic    configuring,
    output dr_sel_t sel
);

    // Gate each code by the configuration phase.
    always_comb begin
        sel = '0;
        case (ir_hold)
            OP_SAMPLE:    sel.bnd = 1'b1;
            OP_IDCODE:    sel.idc = 1'b1;
            OP_EXTEST:    if (!configuring) begin sel.bnd = 1'b1; sel.ext = 1'b1; end
                          else sel.byp = 1'b1;
            OP_USER1:     if (!configuring) sel.usr1 = 1'b1; else sel.byp = 1'b1;
            OP_USER2:     if (!configuring) sel.usr2 = 1'b1; else sel.byp = 1'b1;
            OP_READBACK:  if (!configuring) sel.rdbk = 1'b1; else sel.byp = 1'b1;
            OP_CONFIGURE: if (!configuring) sel.cfgp = 1'b1; else sel.byp = 1'b1;
            default:      sel.byp = 1'b1;
        endcase
    end

endmodule

// File: rtl/jtag_tap_dr.sv
// Internal data registers: one-bit bypass and identification register.
// Each register captures and shifts only while it is the selected one.
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter logic [3:0] ID_VERSION = 4'h0
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_sel_t    sel,
    output logic       int_tdo
);

    localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_FAMILY, ID_ARRAY, ID_MFR, 1'b1};

    logic            byp_q;
    logic [ID_W-1:0] id_q;

    // Bypass stage: capture zero, then shift tdi.
    always_ff @(posedge tck) begin
        if (!trst_n)                             byp_q <= 1'b0;
        else if (sel.byp && state == ST_DR_CAP)   byp_q <= 1'b0;
        else if (sel.byp && state == ST_DR_SHIFT) byp_q <= tdi;
    end

    // Identification register: capture constant, shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                             id_q <= '0;
        else if (sel.idc && state == ST_DR_CAP)   id_q <= ID_VALUE;
        else if (sel.idc && state == ST_DR_SHIFT) id_q <= {tdi, id_q[ID_W-1:1]};
    end

    assign int_tdo = sel.idc ? id_q[0] : byp_q;

endmodule

// File: rtl/jtag_cfg_tap.sv
// Top of the configuration-aware test access port.
// Retimes tdo to falling tck and exposes selects and strobes for the
// external chains, whose serial outputs return on ext_tdo.
module jtag_cfg_tap
    import jtag_tap_pkg::*;
#(
    parameter logic [3:0] ID_VERSION = 4'h0
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic configuring,
    input  logic ext_tdo,
    output logic tdo,
    output logic tdo_oe,
    output logic sel_boundary,
    output logic sel_user1,
    output logic sel_user2,
    output logic sel_readback,
    output logic sel_configure,
    output logic extest_mode,
    output logic dr_capture,
    output logic dr_shift,
    output logic dr_update
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_sr;
    opcode_e         ir_hold;
    dr_sel_t         sel;
    logic            int_tdo;
    logic            tdo_d;
    logic            in_shift;

    jtag_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    jtag_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .configuring(configuring),
        .state(state), .ir_sr(ir_sr), .ir_hold(ir_hold)
    );

    jtag_tap_decode u_dec (
        .ir_hold(ir_hold), .configuring(configuring), .sel(sel)
    );

    jtag_tap_dr #(.ID_VERSION(ID_VERSION)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
        .sel(sel), .int_tdo(int_tdo)
    );

    assign in_shift = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);

    // Serial source for the current shift state.
    always_comb begin
        if (state == ST_IR_SHIFT)       tdo_d = ir_sr[0];
        else if (state == ST_DR_SHIFT)  tdo_d = (sel.byp || sel.idc) ? int_tdo : ext_tdo;
        else                            tdo_d = 1'b0;
    end

    // Output retiming on falling tck.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= tdo_d;
            tdo_oe <= in_shift;
        end
    end

    assign sel_boundary  = sel.bnd;
    assign sel_user1     = sel.usr1;
    assign sel_user2     = sel.usr2;
    assign sel_readback  = sel.rdbk;
    assign sel_configure = sel.cfgp;
    assign extest_mode   = sel.ext;
    assign dr_capture    = (state == ST_DR_CAP);
    assign dr_shift      = (state == ST_DR_SHIFT);
    assign dr_update     = (state == ST_DR_UPD);

endmodule

// File: rtl/jtag_cfg_tap_chk.sv
// Property checker for jtag_cfg_tap, attached through bind.
// Assumes trst_n is low for at least one rising tck before checks count.
module jtag_cfg_tap_chk
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            configuring,
    input logic            tdo_oe,
    input logic            sel_boundary,
    input logic            sel_user1,
    input logic            sel_user2,
    input logic            sel_readback,
    input logic            sel_configure,
    input logic            extest_mode,
    input logic            dr_update,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_sr,
    input opcode_e         ir_hold
);

    // R9
    oe_only_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

    // R6
    blocked_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        configuring |-> !(sel_user1 || sel_user2 || sel_readback || sel_configure || extest_mode));

    // R7
    one_select_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({sel_boundary, sel_user1, sel_user2, sel_readback, sel_configure}));

    // R7
    extest_needs_bnd_chk: assert property (@(posedge tck) disable iff (!trst_n)
        extest_mode |-> sel_boundary);

    // R5
    ir_hold_stable_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_IR_UPD && state != ST_RESET) |=> $stable(ir_hold));

    // R2
    reset_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir_hold == OP_IDCODE));

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_CAP) |=> (ir_sr[0] && !ir_sr[1] && ir_sr[IR_W-1] == !$past(configuring)));

    // R10
    update_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
        dr_update |-> ($past(state) == ST_DR_EXIT1 || $past(state) == ST_DR_EXIT2));

endmodule

bind jtag_cfg_tap jtag_cfg_tap_chk u_chk (.*);

// File: tb/sim_jtag_cfg_tap.sv
`timescale 1ns/1ps
module sim_jtag_cfg_tap;

    localparam logic [3:0] VER  = 4'hA;
    localparam int         BLEN = 247;
    localparam logic [31:0] ID_EXP = {VER, 7'b0000010, 9'b000001010, 11'b00001001001, 1'b1};

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, configuring = 1'b1;
    logic ext_tdo;
    logic tdo, tdo_oe, sel_boundary, sel_user1, sel_user2, sel_readback, sel_configure;
    logic extest_mode, dr_capture, dr_shift, dr_update;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 tck = ~tck;

    jtag_cfg_tap #(.ID_VERSION(VER)) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .configuring(configuring),
        .ext_tdo(ext_tdo), .tdo(tdo), .tdo_oe(tdo_oe), .sel_boundary(sel_boundary),
        .sel_user1(sel_user1), .sel_user2(sel_user2), .sel_readback(sel_readback),
        .sel_configure(sel_configure), .extest_mode(extest_mode),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update)
    );

    // ---- external chains (environment) ----
    logic [BLEN-1:0] bsr, bsr_init;
    logic [7:0]  u1c = 8'hC5;
    logic [11:0] u2c = 12'hA3C;
    logic [4:0]  rbc = 5'b10110;
    logic [4:0]  cfc = 5'b01101;
    logic sh_b = 0, sh_1 = 0, sh_2 = 0, sh_r = 0, sh_c = 0;

    initial begin
        for (int i = 0; i < BLEN; i++) bsr_init[i] = ((i * 7) % 5) < 2;
        bsr = bsr_init;
    end

    assign ext_tdo = sel_boundary  ? bsr[0] :
                     sel_user1     ? u1c[0] :
                     sel_user2     ? u2c[0] :
                     sel_readback  ? rbc[0] :
                     sel_configure ? cfc[0] : 1'b0;

    always @(posedge tck) begin
        if (sh_b) bsr <= {tdi, bsr[BLEN-1:1]};
        if (sh_1) u1c <= {tdi, u1c[7:1]};
        if (sh_2) u2c <= {tdi, u2c[11:1]};
        if (sh_r) rbc <= {tdi, rbc[4:1]};
        if (sh_c) cfc <= {tdi, cfc[4:1]};
    end

    // ---- behavioural reference model ----
    int nx0 [16] = '{1, 1, 3, 4, 4, 6, 6, 4, 1, 10, 11, 11, 13, 13, 11, 1};
    int nx1 [16] = '{0, 2, 9, 5, 5, 8, 7, 8, 2, 0, 12, 12, 15, 14, 15, 2};
    int m_st = 0;
    logic [2:0]  m_ir = 3'b110;
    logic [2:0]  m_irsr = 3'b000;
    logic        m_byp = 1'b0;
    logic [31:0] m_id = 32'h0;
    bit rst_seen = 0;

    // 0 bypass, 1 id, 2 sample, 3 extest, 4 user1, 5 user2, 6 readback, 7 configure
    function automatic int m_sel(logic [2:0] op, logic cf);
        if (op == 3'b110) return 1;
        if (op == 3'b111) return 0;
        if (op == 3'b001) return 2;
        if (cf) return 0;
        if (op == 3'b000) return 3;
        if (op == 3'b010) return 4;
        if (op == 3'b011) return 5;
        if (op == 3'b100) return 6;
        return 7;
    endfunction

    always @(posedge tck) begin
        int s;
        s = m_sel(m_ir, configuring);
        if (!trst_n) begin
            rst_seen = 1;
            m_st = 0; m_ir = 3'b110; m_irsr = 3'b000; m_byp = 1'b0; m_id = 32'h0;
        end else begin
            if (m_st == 3 && s == 0) m_byp = 1'b0;
            if (m_st == 3 && s == 1) m_id = ID_EXP;
            if (m_st == 4 && s == 0) m_byp = tdi;
            if (m_st == 4 && s == 1) m_id = {tdi, m_id[31:1]};
            if (m_st == 10) m_irsr = {~configuring, 2'b01};
            if (m_st == 11) m_irsr = {tdi, m_irsr[2:1]};
            if (m_st == 15) m_ir = m_irsr;
            if (m_st == 0)  m_ir = 3'b110;
            m_st = tms ? nx1[m_st] : nx0[m_st];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge tck) begin
        int s;
        logic exp_oe, exp_tdo;
        logic [8:0] exp_v, act_v;
        #1;
        s = m_sel(m_ir, configuring);
        sh_b = dr_shift & sel_boundary;
        sh_1 = dr_shift & sel_user1;
        sh_2 = dr_shift & sel_user2;
        sh_r = dr_shift & sel_readback;
        sh_c = dr_shift & sel_configure;
        if (rst_seen) begin
            exp_oe  = trst_n && (m_st == 4 || m_st == 11);
            exp_tdo = 1'b0;
            if (exp_oe && m_st == 11) exp_tdo = m_irsr[0];
            else if (exp_oe) begin
                case (s)
                    0: exp_tdo = m_byp;
                    1: exp_tdo = m_id[0];
                    2, 3: exp_tdo = bsr[0];
                    4: exp_tdo = u1c[0];
                    5: exp_tdo = u2c[0];
                    6: exp_tdo = rbc[0];
                    default: exp_tdo = cfc[0];
                endcase
            end
            chk(tdo_oe === exp_oe && tdo === exp_tdo, "R9 per-cycle tdo/tdo_oe",
                {tdo_oe, tdo}, {exp_oe, exp_tdo});
            exp_v = {s == 2 || s == 3, s == 4, s == 5, s == 6, s == 7, s == 3,
                     m_st == 3, m_st == 4, m_st == 8};
            act_v = {sel_boundary, sel_user1, sel_user2, sel_readback, sel_configure,
                     extest_mode, dr_capture, dr_shift, dr_update};
            chk(act_v === exp_v, "R10/R7/R1 per-cycle selects and strobes", act_v, exp_v);
        end
    end

    // Watchdog.
    always @(posedge tck) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---- stimulus helpers ----
    task automatic tick(input logic tms_v, input logic tdi_v, output logic tdo_v);
        tms = tms_v; tdi = tdi_v;
        @(negedge tck); #1;
        tdo_v = tdo;
        @(posedge tck); #1;
    endtask

    task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap);
        logic d;
        tick(1, 0, d); tick(1, 0, d); tick(0, 0, d); tick(0, 0, d);
        for (int i = 0; i < 3; i++) tick(i == 2, op[i], cap[i]);
        tick(1, 0, d); tick(0, 0, d);
    endtask

    task automatic scan_dr(input int n, input logic [255:0] din, output logic [255:0] dout);
        logic d;
        dout = '0;
        tick(1, 0, d); tick(0, 0, d); tick(0, 0, d);
        for (int i = 0; i < n; i++) tick(i == n - 1, din[i], dout[i]);
        tick(1, 0, d); tick(0, 0, d);
    endtask

    initial begin
        logic [2:0] cap;
        logic [255:0] dout, din;
        logic d, a, b;

        repeat (3) @(posedge tck);
        #1 trst_n = 1'b1;
        chk(tdo_oe === 1'b0 && sel_boundary === 1'b0 && extest_mode === 1'b0,
            "R2 reset state oe/selects", {tdo_oe, sel_boundary, extest_mode}, 3'b000);
        tick(0, 0, d);

        // R2 / R4: identification after reset
        scan_dr(32, '0, dout);
        chk(dout[31:0] === ID_EXP, "R2 R4 id after reset", dout[31:0], ID_EXP);
        chk(dout[0] === 1'b1, "R4 id bit0", dout[0], 1'b1);

        // R3: capture while configuring
        scan_ir(3'b111, cap);
        chk(cap === 3'b001, "R3 capture configuring", cap, 3'b001);

        // R8: bypass delay
        din = 256'hB3;
        scan_dr(8, din, dout);
        chk(dout[7:0] === {din[6:0], 1'b0}, "R8 bypass one-stage delay", dout[7:0], {din[6:0], 1'b0});

        // R6: blocked codes while configuring
        scan_ir(3'b010, cap);
        chk(sel_user1 === 1'b0, "R6 user1 blocked", sel_user1, 1'b0);
        din = 256'h2D;
        scan_dr(6, din, dout);
        chk(dout[5:0] === {din[4:0], 1'b0}, "R6 user1 acts as bypass", dout[5:0], {din[4:0], 1'b0});
        scan_ir(3'b000, cap);
        chk(extest_mode === 1'b0 && sel_boundary === 1'b0, "R6 extest blocked",
            {extest_mode, sel_boundary}, 2'b00);
        scan_ir(3'b100, cap);
        chk(sel_readback === 1'b0, "R6 readback blocked", sel_readback, 1'b0);
        scan_ir(3'b101, cap);
        chk(sel_configure === 1'b0, "R6 configure blocked", sel_configure, 1'b0);

        // R7: sample allowed while configuring; 247-cell chain through ext_tdo
        scan_ir(3'b001, cap);
        chk(sel_boundary === 1'b1 && extest_mode === 1'b0, "R7 sample selects boundary",
            {sel_boundary, extest_mode}, 2'b10);
        din = 256'h5A;
        scan_dr(BLEN + 8, din, dout);
        chk(dout[BLEN-1:0] === bsr_init, "R7 boundary contents", dout[BLEN-1:0], bsr_init);
        chk(dout[BLEN+7:BLEN] === din[7:0], "R7 boundary length", dout[BLEN+7:BLEN], din[7:0]);

        // Leave configuration phase
        configuring = 1'b0;
        tick(0, 0, d);

        // R3 capture after configuration, R7 extest honoured
        scan_ir(3'b000, cap);
        chk(cap === 3'b101, "R3 capture configured", cap, 3'b101);
        chk(extest_mode === 1'b1 && sel_boundary === 1'b1, "R7 extest honoured",
            {extest_mode, sel_boundary}, 2'b11);

        // R7: user2 chain
        scan_ir(3'b011, cap);
        chk(sel_user2 === 1'b1, "R7 user2 selected", sel_user2, 1'b1);
        scan_dr(16, 256'hF, dout);
        chk(dout[11:0] === 12'hA3C, "R7 user2 data via ext_tdo", dout[11:0], 12'hA3C);
        scan_ir(3'b100, cap);
        chk(sel_readback === 1'b1, "R7 readback honoured", sel_readback, 1'b1);

        // R5: instruction held until Update-IR
        scan_ir(3'b001, cap);
        tick(1, 0, d); tick(1, 0, d); tick(0, 0, d); tick(0, 0, d);
        tick(0, 0, d); tick(0, 1, d); tick(1, 0, d);
        tick(0, 0, d);
        chk(sel_boundary === 1'b1 && sel_user1 === 1'b0, "R5 held during Pause-IR",
            {sel_boundary, sel_user1}, 2'b10);
        tick(1, 0, d); tick(1, 0, d); tick(0, 0, d);
        chk(sel_user1 === 1'b1 && sel_boundary === 1'b0, "R5 applied at Update-IR",
            {sel_user1, sel_boundary}, 2'b01);

        // R9 / R10 / R1: falling-edge tdo, strobes, five-tms reset
        scan_ir(3'b111, cap);
        tick(1, 0, d); tick(0, 0, d);
        chk(dr_capture === 1'b1 && dr_shift === 1'b0, "R10 capture strobe", {dr_capture, dr_shift}, 2'b10);
        tick(0, 0, d);
        tms = 1'b1; tdi = 1'b1;
        @(negedge tck); #1 a = tdo;
        chk(tdo_oe === 1'b1 && a === 1'b0, "R9 shift bit valid after fall", {tdo_oe, a}, 2'b10);
        @(posedge tck); #1 b = tdo;
        chk(b === 1'b0, "R9 tdo held across rising edge", b, 1'b0);
        @(negedge tck); #1;
        chk(tdo_oe === 1'b0 && tdo === 1'b0, "R9 oe low outside shift", {tdo_oe, tdo}, 2'b00);
        @(posedge tck); #1;
        for (int i = 0; i < 3; i++) tick(1, 0, d);
        chk(tdo_oe === 1'b0, "R1 reached reset after five tms high", tdo_oe, 1'b0);
        tick(0, 0, d);
        scan_dr(32, '0, dout);
        chk(dout[31:0] === ID_EXP, "R1 R2 id after tms reset", dout[31:0], ID_EXP);

        // R2: trst during a non-reset instruction
        scan_ir(3'b010, cap);
        trst_n = 1'b0;
        @(posedge tck); #1 trst_n = 1'b1;
        tick(0, 0, d);
        scan_dr(32, '0, dout);
        chk(dout[31:0] === ID_EXP, "R2 id after trst", dout[31:0], ID_EXP);

        repeat (2) @(posedge tck);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule